// File: doc/BRIEF.md
# Serial Receive Byte Queue

This block holds the bytes that a serial receiver's deserializer delivers until host software reads them. Each accepted byte arrives on a one-cycle receive strobe with its data. The host removes bytes through a read strobe and sees the oldest held byte on a read-data output. A control byte written over the bus sets three things: whether the block runs as a 16-entry first-in first-out queue or as a single holding register, whether the queue is emptied, and which fill level raises the threshold flag.

The block produces several outputs for the rest of the serial port. Data-ready and overrun feed the line status. The fill count shows how many bytes are held. The threshold flag is used by the interrupt logic. The two modes treat a byte that finds no room differently. Queue mode drops the new byte. Holding-register mode overwrites the unread byte. In both modes the overrun flag is raised.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the block is in holding-register mode with threshold code 0. Fill count is 0, data-ready and overrun are low, the threshold flag is low and read data is 0x00.
- R2: In queue mode (control bit 0 = 1) up to DEPTH (16) bytes are held and read out in arrival order. The fill count never exceeds DEPTH.
- R3: In queue mode, a byte that arrives while the queue is full, with no read in the same cycle, is dropped. The held contents and the count stay unchanged and overrun is set.
- R4: In holding-register mode (control bit 0 = 0) at most one byte is held. A byte that arrives while an unread byte is held, with no read in the same cycle, overwrites it and sets overrun.
- R5: Data-ready is set by every stored byte. Data-ready and overrun both clear when a read leaves the block empty.
- R6: A read while empty shows read data 0x00 and changes no state.
- R7: A control write sets the mode from bit 0. A control write with bit 0 = 0 while queue mode is on empties the block. A control write with bit 0 = 1 keeps the held contents.
- R8: A control write with bit 1 = 1 empties the block and clears data-ready. Overrun is left unchanged.
- R9: Control bits [7:6] select the threshold level: code 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. The threshold flag follows combinationally as fill count >= level. The level applies in both modes.
- R10: A read and a stored byte in the same cycle leave the fill count unchanged. This includes a full queue, where the new byte is kept and overrun is not set.
- R11: In a cycle whose control write empties the block, the receive strobe and the read strobe of that cycle are ignored. A control write that does not empty the block acts on the receive strobe under the mode held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_byte | input | 8 | Control byte: [0] queue mode, [1] empty, [7:6] threshold code |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rd_en | input | 1 | Host read strobe; removes the oldest byte |
| rd_data | output | 8 | Oldest held byte, 0x00 when empty |
| data_ready | output | 1 | At least one unread byte |
| overrun | output | 1 | A byte was dropped or overwritten |
| fill_count | output | 5 | Bytes held, 0..DEPTH |
| thresh_hit | output | 1 | Fill count has reached the selected level |

## Verification
The bench builds the block with its default DEPTH of 16 and 8-bit data. At this size the queue can be filled to the 14-byte level and past it to full in a few dozen cycles. The directed part uses these short runs to hit the full-queue drop, the read-and-write on a full queue, and every threshold crossing. A long constrained-random phase then mixes mode switches, queue emptying and simultaneous strobes, so that pointer wrap and mode-change corner cases are compared against the queue model on every cycle.

// File: rtl/uart_rxq_pkg.sv
`timescale 1ns/1ps
package uart_rxq_pkg;

  typedef struct packed {
    logic       fifo_en;
    logic [1:0] trig_code;
  } rxq_ctrl_t;

  // Threshold level chosen by the 2-bit code (1, quarter, half, depth-2).
  function automatic int unsigned trig_level(input logic [1:0] code,
                                             input int unsigned depth);
    case (code)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  // Occupancy after one cycle of store / remove.
  function automatic int unsigned fill_next(input int unsigned fill,
                                            input logic push,
                                            input logic pop);
    return fill + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl
  import uart_rxq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctl_we,
  input  logic      mode_bit,
  input  logic      empty_bit,
  input  logic [1:0] code_bits,
  output rxq_ctrl_t ctrl,
  output logic      flush
);

  rxq_ctrl_t ctrl_q;

  // Emptying: explicit request, or leaving queue mode.
  assign flush = ctl_we && (empty_bit || (ctrl_q.fifo_en && !mode_bit));
  assign ctrl  = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctl_we) begin
      ctrl_q.fifo_en   <= mode_bit;
      ctrl_q.trig_code <= code_bits;
    end
  end

  p_leave_mode_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctrl.fifo_en && !mode_bit) |=> !ctrl.fifo_en);

endmodule

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              replace,
  input  logic              pop,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [DATA_W-1:0] head_byte
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [PTR_W-1:0]  wr_slot;
  logic              mem_we;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // An overwrite in holding-register mode lands on the unread slot.
  assign wr_slot   = replace ? rd_ptr : wr_ptr;
  assign mem_we    = push || replace;
  assign head_byte = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_slot] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
    end
  end

  p_store_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && replace));

endmodule

// File: rtl/rxq_status.sv
`timescale 1ns/1ps
module rxq_status
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic             replace,
  input  logic             set_ov,
  input  logic [1:0]       trig_code,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             data_ready,
  output logic             overrun,
  output logic             thresh_hit
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] level;
  logic             drain;
  logic             dr_q, ov_q;

  assign count      = count_q;
  assign empty      = (count_q == '0);
  assign full       = (count_q == CNT_W'(DEPTH));
  assign level      = CNT_W'(trig_level(trig_code, DEPTH));
  assign thresh_hit = (count_q >= level);
  // A read that takes the last byte with nothing new stored.
  assign drain      = pop && (count_q == CNT_W'(1)) && !push;
  assign data_ready = dr_q;
  assign overrun    = ov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      dr_q    <= 1'b0;
      ov_q    <= 1'b0;
    end else begin
      if (flush) count_q <= '0;
      else       count_q <= CNT_W'(fill_next(int'(count_q), push, pop));

      if (flush)                dr_q <= 1'b0;
      else if (push || replace) dr_q <= 1'b1;
      else if (drain)           dr_q <= 1'b0;

      if (set_ov)     ov_q <= 1'b1;
      else if (drain) ov_q <= 1'b0;
    end
  end

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  p_ready_tracks_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready == !empty);

  p_ov_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(set_ov));

  p_top_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_code == 2'd3 && count_q == CNT_W'(DEPTH - 2)) |-> thresh_hit);

endmodule

// File: rtl/uart_rx_queue.sv
`timescale 1ns/1ps
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_byte,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_ready,
  output logic              overrun,
  output logic [CNT_W-1:0]  fill_count,
  output logic              thresh_hit
);

  rxq_ctrl_t         ctrl;
  logic              flush;
  logic              empty, full;
  logic              rd_fire, rx_take, replace, discard, push, set_ov;
  logic [DATA_W-1:0] head_byte;
  logic              unused_ctl;

  assign unused_ctl = &{1'b0, ctl_byte[5:2]};

  // Named events for the datapath and the assertions.
  assign rd_fire = rd_en && !empty && !flush;
  assign rx_take = rx_valid && !flush;
  assign replace = rx_take && !ctrl.fifo_en && !empty && !rd_fire;
  assign discard = rx_take && ctrl.fifo_en && full && !rd_fire;
  assign push    = rx_take && !replace && !discard;
  assign set_ov  = replace || discard;
  assign rd_data = empty ? '0 : head_byte;

  rxq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .mode_bit  (ctl_byte[0]),
    .empty_bit (ctl_byte[1]),
    .code_bits (ctl_byte[7:6]),
    .ctrl      (ctrl),
    .flush     (flush)
  );

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push),
    .replace   (replace),
    .pop       (rd_fire),
    .wr_byte   (rx_byte),
    .head_byte (head_byte)
  );

  rxq_status #(.DEPTH(DEPTH)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .push       (push),
    .pop        (rd_fire),
    .replace    (replace),
    .set_ov     (set_ov),
    .trig_code  (ctrl.trig_code),
    .count      (fill_count),
    .empty      (empty),
    .full       (full),
    .data_ready (data_ready),
    .overrun    (overrun),
    .thresh_hit (thresh_hit)
  );

  p_single_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.fifo_en |-> fill_count <= CNT_W'(1));

  p_discard_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> (overrun && fill_count == $past(fill_count)));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill_count == '0 && !data_ready));

  p_same_cycle_rw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && rd_fire) |=> fill_count == $past(fill_count));

  p_empty_read_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fill_count == '0 && !rx_valid && !ctl_we)
      |=> ($stable(fill_count) && $stable(overrun) && $stable(data_ready)));

  p_empty_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == '0) |-> (rd_data == '0));

endmodule

// File: tb/test_uart_rx_queue.sv
`timescale 1ns/1ps
module test_uart_rx_queue;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_we;
  logic [7:0] ctl_byte;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       data_ready, overrun, thresh_hit;
  logic [4:0] fill_count;

  always #5 clk = ~clk;

  uart_rx_queue i_uart_rx_queue (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_byte(ctl_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_en(rd_en), .rd_data(rd_data),
    .data_ready(data_ready), .overrun(overrun), .fill_count(fill_count),
    .thresh_hit(thresh_hit)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference model state
  byte unsigned mq[$];
  bit m_fen, m_dr, m_ov;
  int m_code;

  function automatic int lvl_of(input int code);
    if (code == 0) return 1;
    if (code == 1) return 4;
    if (code == 2) return 8;
    return 14;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic check_outputs(input string tag);
    int sz;
    sz = mq.size();
    chk(tag, "fill_count", 32'(fill_count), 32'(sz));
    chk(tag, "data_ready", 32'(data_ready), 32'(m_dr));
    chk(tag, "overrun",    32'(overrun),    32'(m_ov));
    chk(tag, "thresh_hit", 32'(thresh_hit), 32'(sz >= lvl_of(m_code)));
    chk(tag, "rd_data",    32'(rd_data),    32'(sz > 0 ? mq[0] : 8'h00));
  endtask

  task automatic model_step(input bit cwe, input byte unsigned cb,
                            input bit rv, input byte unsigned rb, input bit rd);
    bit fen_old, flush, rdf, pushed;
    int n;
    fen_old = m_fen;
    flush = cwe && (cb[1] || (m_fen && !cb[0]));
    if (cwe) begin
      m_fen  = cb[0];
      m_code = int'(cb[7:6]);
    end
    if (flush) begin
      mq.delete();
      m_dr = 0;
    end else begin
      n = mq.size();
      rdf = rd && (n > 0);
      pushed = 0;
      if (rdf) void'(mq.pop_front());
      if (rv) begin
        if (fen_old) begin
          if (n < DEPTH || rdf) begin mq.push_back(rb); pushed = 1; end
          else m_ov = 1;
        end else if (n > 0 && !rdf) begin
          mq[0] = rb; m_ov = 1; m_dr = 1;
        end else begin
          mq.push_back(rb); pushed = 1;
        end
      end
      if (pushed) m_dr = 1;
      if (rdf && n == 1 && !pushed) begin m_dr = 0; m_ov = 0; end
    end
  endtask

  // One clock: drive, compare state-only outputs, clock, update model.
  task automatic cyc(input string tag, input bit cwe, input byte unsigned cb,
                     input bit rv, input byte unsigned rb, input bit rd);
    ctl_we = cwe; ctl_byte = cb; rx_valid = rv; rx_byte = rb; rd_en = rd;
    #1;
    check_outputs(tag);
    @(posedge clk);
    model_step(cwe, cb, rv, rb, rd);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 8'h00, 0, 8'h00, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_we = 0; ctl_byte = 0; rx_valid = 0; rx_byte = 0; rd_en = 0;
    m_fen = 0; m_dr = 0; m_ov = 0; m_code = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1");
    idle("R1");

    // Holding-register mode
    cyc("R5", 0, 0, 1, 8'h11, 0);
    cyc("R4", 0, 0, 1, 8'h22, 0);   // overwrite, overrun
    idle("R4");
    cyc("R4", 0, 0, 1, 8'h33, 1);   // read and store same cycle
    cyc("R5", 0, 0, 0, 0, 1);       // read leaves empty
    cyc("R6", 0, 0, 0, 0, 1);       // read while empty
    idle("R6");

    // Queue mode, top threshold
    cyc("R7", 1, 8'hC1, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) cyc("R9", 0, 0, 1, 8'(i * 7 + 3), 0);
    cyc("R3", 0, 0, 1, 8'hEE, 0);   // full, dropped
    idle("R3");
    cyc("R10", 0, 0, 1, 8'h5A, 1);  // full, read + store
    idle("R10");
    for (int i = 0; i < DEPTH; i++) cyc("R2", 0, 0, 0, 0, 1);
    cyc("R6", 0, 0, 0, 0, 1);

    // Other threshold codes
    cyc("R9", 1, 8'h41, 0, 0, 0);
    for (int i = 0; i < 9; i++) cyc("R9", 0, 0, 1, 8'(8'hA0 + i), 0);
    cyc("R9", 1, 8'h81, 0, 0, 0);
    idle("R9");
    cyc("R9", 1, 8'h01, 0, 0, 0);
    idle("R9");

    // Empty request with strobes in the same cycle
    cyc("R11", 1, 8'h43, 1, 8'h77, 1);
    idle("R8");
    // Overrun survives emptying
    for (int i = 0; i < DEPTH + 1; i++) cyc("R3", 0, 0, 1, 8'(i), 0);
    cyc("R8", 1, 8'h03, 0, 0, 0);
    idle("R8");
    cyc("R5", 0, 0, 1, 8'h44, 0);
    cyc("R5", 0, 0, 0, 0, 1);
    idle("R5");

    // Leaving queue mode empties; entering keeps content
    for (int i = 0; i < 3; i++) cyc("R7", 0, 0, 1, 8'(8'h60 + i), 0);
    cyc("R7", 1, 8'h00, 0, 0, 0);
    idle("R7");
    cyc("R7", 0, 0, 1, 8'h99, 0);
    cyc("R11", 1, 8'h01, 1, 8'h9A, 0); // old mode: overwrite
    cyc("R7", 0, 0, 1, 8'h9B, 0);
    idle("R2");

    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      bit cwe, rv, rd;
      byte unsigned cb;
      cwe = ($urandom_range(0, 49) == 0);
      cb  = 8'($urandom);
      if ($urandom_range(0, 3) != 0) cb[1] = 1'b0;
      if ($urandom_range(0, 3) != 0) cb[0] = 1'b1;
      rv  = ($urandom_range(0, 1) == 1);
      rd  = ($urandom_range(0, 2) == 0);
      cyc("R2", cwe, cb, rv, 8'($urandom), rd);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule